// File: doc/BRIEF.md
# Capture/Reload Timer with Baud Output

A 16-bit timer/counter that shares one counter between three behaviours, chosen by an 8-bit control register: capturing the counter on a falling edge of a trigger pin, reloading itself from a 16-bit reload register, or acting as a baud-rate generator whose overflows clock a serial receiver and transmitter. The counter advances either once every twelve system clocks or once per falling edge of an external count pin. Both pins are resynchronised on entry.

Software sees the control register, the two counter bytes and the two reload bytes through a simple byte-wide register port. Read data is combinational from the address, and a write takes effect at the next clock edge. An overflow flag and an external-event flag are sticky until software clears them. Together with an external enable input they form an interrupt request. In baud mode the flags stay quiet, and one-cycle overflow pulses go out to the receive side, the transmit side, or both.

Top module: `cap_reload_timer`

## Requirements
- R1: After reset, every register reads 0 and tf_o, exf_o, irq_o, rx_clk_pulse_o and tx_clk_pulse_o are 0.
- R2: Register map by addr_i: 0 control, 1 counter low byte, 2 counter high byte, 3 reload low byte, 4 reload high byte, 5 to 7 read 0. Control bits: 7 overflow flag, 6 event flag, 5 receive-baud select, 4 transmit-baud select, 3 trigger enable, 2 run, 1 count-pin select, 0 capture select. A write with wr_en_i=1 is visible on the next read.
- R3: With run=1 and count-pin select=0, the counter advances once every 12 clocks. The divider restarts whenever that condition is false.
- R4: With run=1 and count-pin select=1, the counter advances once per falling edge of cnt_pin_i. The edge acts at the third rising clock edge after the pin falls.
- R5: With run=0, the counter holds and trigger edges have no effect.
- R6: The overflow flag is set when the counter steps from 0xFFFF outside baud mode, and it holds until software writes 0. A hardware set in the same cycle as a software clear leaves it at 1.
- R7: Capture mode (capture select=1, both baud selects 0): overflow wraps the counter to 0. A trigger edge with trigger enable=1 copies the counter into the reload register and sets the event flag.
- R8: Auto-reload mode (capture select=0, both baud selects 0): overflow loads the reload value. A trigger edge with trigger enable=1 also loads it and sets the event flag. When both occur in one cycle, a single load happens and both flags set.
- R9: Baud mode (either baud select=1): the counter reloads on overflow whatever the capture select is, the overflow flag is never set by hardware, and trigger edges are ignored.
- R10: In baud mode each overflow gives exactly one-cycle pulses, visible in the cycle after the overflow edge: on rx_clk_pulse_o if receive select=1 and on tx_clk_pulse_o if transmit select=1.
- R11: With trigger enable=0, trigger edges neither load, capture nor set the event flag.
- R12: irq_o is 1 exactly when irq_en_i=1 and either flag is 1.
- R13: A software write to a counter or reload byte wins over a hardware update of that byte in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 3 | Register address |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| cnt_pin_i | input | 1 | External count pin (falling edge counts) |
| trig_pin_i | input | 1 | Capture/reload trigger pin (falling edge) |
| irq_en_i | input | 1 | Interrupt enable |
| tf_o | output | 1 | Overflow flag |
| exf_o | output | 1 | External event flag |
| irq_o | output | 1 | Interrupt request |
| rx_clk_pulse_o | output | 1 | Overflow pulse for the serial receiver |
| tx_clk_pulse_o | output | 1 | Overflow pulse for the serial transmitter |

## Verification
In auto-reload mode an overflow and a trigger edge can both demand a load in one cycle. The bench provokes this by presetting the counter to 0xFFFF and dropping both pins on the same clock. It then requires a single load of the reload value with both flags set. A flag set by hardware can also coincide with a software write clearing it; a write placed exactly on the overflow edge must leave the flag at 1. A cycle-level reference model in the bench, fed the same stimulus, judges these cases and the random traffic.

// File: rtl/trt_pkg.sv
package trt_pkg;
  typedef struct packed {
    logic tf;
    logic exf;
    logic rclk;
    logic tclk;
    logic exen;
    logic run;
    logic ext_cnt;
    logic cap_mode;
  } ctrl_t;
endpackage

// File: rtl/trt_edge_sync.sv
module trt_edge_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] fall_o
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    logic [STAGES:0] sh_q, sh_d;

    always_comb begin
      sh_d = {sh_q[STAGES-1:0], pin_i[i]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= sh_d;
    end

    assign fall_o[i] = sh_q[STAGES] & ~sh_q[STAGES-1];

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o[i] |=> !fall_o[i]); // R4
  end
endmodule

// File: rtl/trt_prescaler.sv
module trt_prescaler #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic tick_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q, pre_d;

  always_comb begin
    if (!en_i)              pre_d = '0;
    else if (pre_q == LAST) pre_d = '0;
    else                    pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assign tick_o = en_i & (pre_q == LAST);

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o); // R3
endmodule

// File: rtl/trt_core.sv
module trt_core #(
  parameter int CNT_W = 16,
  localparam int NB   = CNT_W / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             ext_cnt_i,
  input  logic             cap_mode_i,
  input  logic             ext_en_i,
  input  logic             baud_i,
  input  logic             tick_i,
  input  logic             cnt_fall_i,
  input  logic             trig_fall_i,
  input  logic [NB-1:0]    cnt_we_i,
  input  logic [NB-1:0]    rld_we_i,
  input  logic [7:0]       wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] rld_o,
  output logic             ovf_o,
  output logic             trig_ev_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, rld_q, rld_d;
  logic inc, ovf, trig_ev, do_reload, do_cap;

  always_comb begin
    inc       = run_i & (ext_cnt_i ? cnt_fall_i : tick_i);
    ovf       = inc & (&cnt_q);
    trig_ev   = run_i & ext_en_i & ~baud_i & trig_fall_i;
    do_reload = (ovf & (baud_i | ~cap_mode_i)) | (trig_ev & ~cap_mode_i);
    do_cap    = trig_ev & cap_mode_i;
  end

  always_comb begin
    if (do_reload) cnt_d = rld_q;
    else if (inc)  cnt_d = cnt_q + 1'b1;
    else           cnt_d = cnt_q;
    rld_d = do_cap ? cnt_q : rld_q;
    for (int b = 0; b < NB; b++) begin
      if (cnt_we_i[b]) cnt_d[b*8 +: 8] = wdata_i;
      if (rld_we_i[b]) rld_d[b*8 +: 8] = wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rld_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      rld_q <= rld_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign rld_o     = rld_q;
  assign ovf_o     = ovf;
  assign trig_ev_o = trig_ev;

  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && cnt_we_i == '0) |=> $stable(cnt_q)); // R5
  AST_WRAP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && cap_mode_i && !baud_i && cnt_we_i == '0) |=> cnt_q == '0); // R7
  AST_CAPTURE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_ev && cap_mode_i && rld_we_i == '0) |=> rld_q == $past(cnt_q)); // R7
  AST_RELOAD_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !cap_mode_i && cnt_we_i == '0) |=> cnt_q == $past(rld_q)); // R8
endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer #(
  parameter int CNT_W       = 16,
  parameter int PRESCALE    = 12,
  parameter int SYNC_STAGES = 2,
  localparam int NB         = CNT_W / 8,
  localparam int ADDR_W     = $clog2(2 * NB + 1)
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              cnt_pin_i,
  input  logic              trig_pin_i,
  input  logic              irq_en_i,
  output logic              tf_o,
  output logic              exf_o,
  output logic              irq_o,
  output logic              rx_clk_pulse_o,
  output logic              tx_clk_pulse_o
);
  import trt_pkg::*;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  // register write decode
  logic          ctrl_we;
  logic [NB-1:0] cnt_we, rld_we;
  assign ctrl_we = wr_en_i & (int'(addr_i) == 0);
  for (genvar b = 0; b < NB; b++) begin : g_we
    assign cnt_we[b] = wr_en_i & (int'(addr_i) == 1 + b);
    assign rld_we[b] = wr_en_i & (int'(addr_i) == 1 + NB + b);
  end

  ctrl_t ctrl_q, ctrl_d;
  logic  baud;
  assign baud = ctrl_q.rclk | ctrl_q.tclk;

  // pins
  logic [1:0] fall;
  trt_edge_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  ({trig_pin_i, cnt_pin_i}),
    .fall_o (fall)
  );

  logic tick;
  trt_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (ctrl_q.run & ~ctrl_q.ext_cnt),
    .tick_o (tick)
  );

  logic [CNT_W-1:0] cnt, rld;
  logic             ovf, trig_ev;
  trt_core #(.CNT_W(CNT_W)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_i       (ctrl_q.run),
    .ext_cnt_i   (ctrl_q.ext_cnt),
    .cap_mode_i  (ctrl_q.cap_mode),
    .ext_en_i    (ctrl_q.exen),
    .baud_i      (baud),
    .tick_i      (tick),
    .cnt_fall_i  (fall[0]),
    .trig_fall_i (fall[1]),
    .cnt_we_i    (cnt_we),
    .rld_we_i    (rld_we),
    .wdata_i     (wdata_i),
    .cnt_o       (cnt),
    .rld_o       (rld),
    .ovf_o       (ovf),
    .trig_ev_o   (trig_ev)
  );

  // control register: software write first, hardware set last
  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_we)      ctrl_d = ctrl_t'(wdata_i);
    if (ovf && !baud) ctrl_d.tf  = 1'b1;
    if (trig_ev)      ctrl_d.exf = 1'b1;
  end

  logic rx_q, tx_q, rx_d, tx_d;
  always_comb begin
    rx_d = ovf & baud & ctrl_q.rclk;
    tx_d = ovf & baud & ctrl_q.tclk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      rx_q   <= 1'b0;
      tx_q   <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      rx_q   <= rx_d;
      tx_q   <= tx_d;
    end
  end

  // read mux
  always_comb begin
    rdata_o = '0;
    if (int'(addr_i) == 0) rdata_o = ctrl_q;
    for (int b = 0; b < NB; b++) begin
      if (int'(addr_i) == 1 + b)      rdata_o = cnt[b*8 +: 8];
      if (int'(addr_i) == 1 + NB + b) rdata_o = rld[b*8 +: 8];
    end
  end

  assign tf_o           = ctrl_q.tf;
  assign exf_o          = ctrl_q.exf;
  assign irq_o          = irq_en_i & (ctrl_q.tf | ctrl_q.exf);
  assign rx_clk_pulse_o = rx_q;
  assign tx_clk_pulse_o = tx_q;

  AST_TF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.tf && !ctrl_we) |=> ctrl_q.tf); // R6
  AST_NO_TF_IN_BAUD: assert property (@(posedge clk) disable iff (!rst_n)
    (baud && !ctrl_we) |=> !$rose(ctrl_q.tf)); // R9
  AST_PULSE_NO_TF: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_clk_pulse_o || tx_clk_pulse_o) |-> !tf_o || $past(tf_o) || $past(ctrl_we)); // R10
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> irq_en_i); // R12
endmodule

// File: tb/cap_reload_timer_tb.sv
module cap_reload_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] addr = '0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       cnt_pin = 1'b1, trig_pin = 1'b1, irq_en = 1'b0;
  logic       tf, exf, irq, rxp, txp;

  always #4 clk = ~clk;

  cap_reload_timer dut_i (
    .clk(clk), .rst_ni(rst_ni), .addr_i(addr), .wr_en_i(wr), .wdata_i(wdata),
    .rdata_o(rdata), .cnt_pin_i(cnt_pin), .trig_pin_i(trig_pin), .irq_en_i(irq_en),
    .tf_o(tf), .exf_o(exf), .irq_o(irq), .rx_clk_pulse_o(rxp), .tx_clk_pulse_o(txp)
  );

  int total = 0, bad = 0;
  string phase_req = "R2";
  bit done = 0;

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // reference model, stepped at each rising edge
  logic        m_on = 0;
  logic [7:0]  m_ctrl;
  logic [15:0] m_cnt, m_rld;
  int          m_pre;
  logic [2:0]  m_cs, m_ts;
  logic        m_rx, m_tx;

  function automatic logic [7:0] exp_read(logic [2:0] a);
    case (a)
      3'd0: return m_ctrl;
      3'd1: return m_cnt[7:0];
      3'd2: return m_cnt[15:8];
      3'd3: return m_rld[7:0];
      3'd4: return m_rld[15:8];
      default: return 8'h00;
    endcase
  endfunction

  logic c_fall, t_fall, baud, inc, ovf, tev, tick;
  logic [7:0]  n_ctrl;
  logic [15:0] n_cnt, n_rld;
  always @(posedge clk) if (m_on) begin
    c_fall = m_cs[2] & ~m_cs[1];
    t_fall = m_ts[2] & ~m_ts[1];
    baud   = m_ctrl[5] | m_ctrl[4];
    tick   = m_ctrl[2] & ~m_ctrl[1] & (m_pre == 11);
    inc    = m_ctrl[2] & (m_ctrl[1] ? c_fall : tick);
    ovf    = inc & (m_cnt == 16'hFFFF);
    tev    = m_ctrl[2] & m_ctrl[3] & ~baud & t_fall;
    n_cnt  = m_cnt; n_rld = m_rld; n_ctrl = m_ctrl;
    if ((ovf && (baud || !m_ctrl[0])) || (tev && !m_ctrl[0])) n_cnt = m_rld;
    else if (ovf) n_cnt = 16'h0000;
    else if (inc) n_cnt = m_cnt + 16'd1;
    if (tev && m_ctrl[0]) n_rld = m_cnt;
    if (wr) case (addr)
      3'd0: n_ctrl = wdata;
      3'd1: n_cnt[7:0]  = wdata;
      3'd2: n_cnt[15:8] = wdata;
      3'd3: n_rld[7:0]  = wdata;
      3'd4: n_rld[15:8] = wdata;
      default: ;
    endcase
    if (ovf && !baud) n_ctrl[7] = 1'b1;
    if (tev) n_ctrl[6] = 1'b1;
    m_rx  = ovf & baud & m_ctrl[5];
    m_tx  = ovf & baud & m_ctrl[4];
    m_pre = (m_ctrl[2] && !m_ctrl[1]) ? ((m_pre == 11) ? 0 : m_pre + 1) : 0;
    m_cs  = {m_cs[1:0], cnt_pin};
    m_ts  = {m_ts[1:0], trig_pin};
    m_ctrl = n_ctrl; m_cnt = n_cnt; m_rld = n_rld;
  end

  logic nxt_cp = 1'b1, nxt_tp = 1'b1;

  // one cycle: drive at the falling edge, then compare
  task automatic cyc(logic [2:0] a, logic w, logic [7:0] d);
    @(negedge clk);
    addr = a; wr = w; wdata = d; cnt_pin = nxt_cp; trig_pin = nxt_tp;
    #1;
    chk("R6",  "tf", tf, m_ctrl[7]);
    chk("R8",  "exf", exf, m_ctrl[6]);
    chk("R12", "irq", irq, irq_en & (m_ctrl[7] | m_ctrl[6]));
    chk("R10", "rx pulse", rxp, m_rx);
    chk("R10", "tx pulse", txp, m_tx);
    chk(phase_req, $sformatf("read addr %0d", a), rdata, exp_read(a));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(3'(i % 5), 1'b0, 8'h00);
  endtask

  task automatic wreg(logic [2:0] a, logic [7:0] d);
    cyc(a, 1'b1, d);
  endtask

  task automatic pulse_pins(bit c, bit t, int gap);
    nxt_cp = c ? 1'b0 : nxt_cp; nxt_tp = t ? 1'b0 : nxt_tp;
    idle(gap);
    nxt_cp = 1'b1; nxt_tp = 1'b1;
    idle(gap);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    // R1: reset state, judged without the model
    for (int a = 0; a < 8; a++) begin
      addr = 3'(a); #1;
      chk("R1", $sformatf("reset read %0d", a), rdata, 0);
    end
    chk("R1", "reset outputs", {tf, exf, irq, rxp, txp}, 0);
    @(negedge clk); rst_ni = 1'b1;
    repeat (8) @(negedge clk);
    m_ctrl = '0; m_cnt = '0; m_rld = '0; m_pre = 0;
    m_cs = 3'b111; m_ts = 3'b111; m_rx = 0; m_tx = 0;
    m_on = 1;
    // R2: readback and unmapped
    phase_req = "R2";
    wreg(3'd1, 8'h34); wreg(3'd2, 8'h12); wreg(3'd3, 8'hCD); wreg(3'd4, 8'hAB);
    wreg(3'd6, 8'hFF);
    for (int a = 0; a < 8; a++) cyc(3'(a), 1'b0, 8'h00);
    // R3: timer mode across an overflow in capture mode (wraps, R7)
    phase_req = "R3";
    wreg(3'd1, 8'hF0); wreg(3'd2, 8'hFF); wreg(3'd0, 8'h05);
    idle(260);
    wreg(3'd0, 8'h00); idle(5); wreg(3'd0, 8'h05); idle(30);
    // R5: stopped, triggers enabled but run=0
    phase_req = "R5";
    wreg(3'd0, 8'h0B);
    for (int i = 0; i < 4; i++) pulse_pins(1, 1, 4);
    // R7 and R4: counter mode capture
    phase_req = "R7";
    wreg(3'd0, 8'h0F);
    for (int i = 0; i < 6; i++) pulse_pins(1, i % 2 == 0, 3);
    // R8: overflow and trigger in the same cycle
    phase_req = "R8";
    wreg(3'd3, 8'hFC); wreg(3'd4, 8'hFF);
    wreg(3'd0, 8'h0E); wreg(3'd1, 8'hFF); wreg(3'd2, 8'hFF);
    pulse_pins(1, 1, 5);
    chk("R8", "coincident load", {exf, tf}, 2'b11);
    for (int i = 0; i < 6; i++) pulse_pins(1, 0, 3);
    // R6: hardware set coincides with software clear
    phase_req = "R6";
    wreg(3'd0, 8'h06); wreg(3'd1, 8'hFF); wreg(3'd2, 8'hFF);
    nxt_cp = 1'b0; idle(2);
    wreg(3'd0, 8'h06);
    idle(1);
    chk("R6", "set beats clear", tf, 1);
    nxt_cp = 1'b1; idle(3);
    wreg(3'd0, 8'h06); idle(3);
    // R9 and R10: baud via receive select, timer clock
    phase_req = "R9";
    wreg(3'd3, 8'hF8); wreg(3'd4, 8'hFF);
    wreg(3'd0, 8'h24); idle(300);
    // transmit select, counter clock, triggers ignored
    phase_req = "R10";
    wreg(3'd0, 8'h1F);
    for (int i = 0; i < 20; i++) pulse_pins(1, 1, 2);
    wreg(3'd0, 8'h36);
    for (int i = 0; i < 20; i++) pulse_pins(1, 0, 2);
    // R11: trigger enable off
    phase_req = "R11";
    wreg(3'd0, 8'h07);
    for (int i = 0; i < 4; i++) pulse_pins(0, 1, 4);
    wreg(3'd0, 8'h02);
    for (int i = 0; i < 4; i++) pulse_pins(0, 1, 4);
    // R12: interrupt gating
    phase_req = "R12";
    wreg(3'd0, 8'hC0); irq_en = 1'b1; idle(3); irq_en = 1'b0; idle(3);
    wreg(3'd0, 8'h40); irq_en = 1'b1; idle(3);
    wreg(3'd0, 8'h00); idle(3);
    // R13: software writes against counting
    phase_req = "R13";
    wreg(3'd0, 8'h04);
    for (int i = 0; i < 60; i++) wreg(3'd1, 8'(i));
    // random traffic
    phase_req = "R2";
    for (int i = 0; i < 6000; i++) begin
      logic [7:0] d;
      if ($urandom % 3 == 0) nxt_cp = ~nxt_cp;
      if ($urandom % 5 == 0) nxt_tp = ~nxt_tp;
      if ($urandom % 64 == 0) irq_en = ~irq_en;
      d = 8'($urandom);
      if ($urandom % 16 == 0) begin
        logic [2:0] a;
        a = 3'($urandom % 6);
        if (a == 3'd0) begin
          if ($urandom % 4 != 0) d[2] = 1'b1;
          if ($urandom % 2 == 0) d[5:4] = 2'b00;
        end
        if (a == 3'd1 || a == 3'd2) d = ($urandom % 2) ? 8'hFF : d;
        wreg(a, d);
      end else begin
        cyc(3'($urandom % 8), 1'b0, 8'h00);
      end
    end
    finish_run();
  end
endmodule